// File: doc/BRIEF.md
# Paged Word Address Counter

This block holds the internal byte address of a serial memory with 32,768 bytes, arranged as 512 pages of 64 bytes. The serial front end loads the address from two received address bytes. The high byte arrives first, and only its seven low bits are used. The low byte follows and supplies bits 7..0. The front end then pulses an increment strobe once for each data byte that is transferred.

How the counter advances depends on the direction of the transfer. While writing, only the byte-in-page field moves, so a long burst wraps back to the start of the same page. While reading, the whole address moves, so a burst continues across page boundaries and wraps from the top of the array to zero. The counter keeps its value between transfers. A read that sends no address therefore starts one past the last byte that was accessed.

Top module: `word_addr_ctr`

## Requirements
- R1: While `rst_n` is low, `addr` becomes 0 at the next clock edge, and the staged high bits are also cleared to 0.
- R2: A `load_hi` pulse without `load_lo` leaves `addr` unchanged. It only stages `addr_byte[6:0]` as the future address bits 14..8. Bit 7 of that byte is don't-care.
- R3: A `load_lo` pulse sets `addr` to {staged bits 14..8, `addr_byte[7:0]`} at the next clock edge.
- R4: In write mode (`rd_mode`=0), a `step` pulse increments `addr[5:0]` modulo 64 and keeps `addr[14:6]` (the page number). Byte 63 of a page is followed by byte 0 of the same page.
- R5: In read mode (`rd_mode`=1), a `step` pulse increments the whole 15-bit address. 0x7FFF is followed by 0x0000, and byte 63 of a page is followed by byte 0 of the next page.
- R6: With no strobe active, `addr` holds its value for any number of cycles, so the next transfer starts from the last address plus one.
- R7: When `load_lo` and `step` are active in the same cycle, the load wins and the step is ignored.
- R8: The staged high bits persist after use. A later `load_lo` without a new `load_hi` combines the new low byte with the last staged high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_hi | input | 1 | Stage the high address byte from `addr_byte` |
| load_lo | input | 1 | Load the full address using `addr_byte` as the low byte |
| addr_byte | input | 8 | Received address byte |
| step | input | 1 | Advance the address once, for one data byte |
| rd_mode | input | 1 | 1 selects linear (read) advance, 0 selects in-page (write) advance |
| addr | output | 15 | Current word address |

## Verification
Every result of the counter appears on `addr` one clock edge after the strobe that caused it, because `addr` is a single register with no combinational path from the strobes. The driver changes the strobes on a falling edge. It waits for the next rising edge and, just after it, pushes the address it expects for that edge. The monitor pops and compares that entry on the following falling edge, which is half a cycle after the register update and before the driver's next change. Each check therefore samples exactly the cycle in which that edge's result is due.

// File: rtl/wac_pkg.sv
package wac_pkg;

  // What the address register does on the coming edge.
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_LOAD   = 2'd1,
    SEL_PAGE   = 2'd2,
    SEL_LINEAR = 2'd3
  } wac_sel_e;

endpackage

// File: rtl/wac_ctrl.sv
module wac_ctrl
  import wac_pkg::*;
(
  input  logic     load_lo,
  input  logic     step,
  input  logic     rd_mode,
  output wac_sel_e sel
);

  // The low-byte load takes priority over a step in the same cycle.
  always_comb begin
    if (load_lo)      sel = SEL_LOAD;
    else if (!step)   sel = SEL_HOLD;
    else if (rd_mode) sel = SEL_LINEAR;
    else              sel = SEL_PAGE;
  end

endmodule

// File: rtl/wac_hi_stage.sv
module wac_hi_stage #(
  parameter int HI_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_hi,
  input  logic            load_lo,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q
);

  // Holds the upper address bits until a low-byte load applies them.
  always_ff @(posedge clk) begin
    if (!rst_n)                   hi_q <= '0;
    else if (load_hi && !load_lo) hi_q <= hi_in;
  end

endmodule

// File: rtl/wac_next.sv
module wac_next
  import wac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8,
  localparam int HI_W  = ADDR_W - BYTE_W
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [HI_W-1:0]   hi_q,
  input  logic [BYTE_W-1:0] lo_byte,
  input  wac_sel_e          sel,
  output logic [ADDR_W-1:0] nxt,
  output logic              page_wrap,
  output logic              array_wrap
);

  function automatic logic [ADDR_W-1:0] linear_inc(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [ADDR_W-1:0] paged;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      // The page covers the whole array, so in-page and linear advance agree.
      assign paged = linear_inc(cur);
    end else begin : g_paged
      function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] off;
        off = a[PAGE_W-1:0] + 1'b1;
        return {a[ADDR_W-1:PAGE_W], off};
      endfunction
      assign paged = page_inc(cur);
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_LOAD:   nxt = {hi_q, lo_byte};
      SEL_PAGE:   nxt = paged;
      SEL_LINEAR: nxt = linear_inc(cur);
      default:    nxt = cur;
    endcase
  end

  assign page_wrap  = (sel == SEL_PAGE) && (&cur[PAGE_W-1:0]);
  assign array_wrap = (sel == SEL_LINEAR) && (&cur);

endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
  import wac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              step,
  input  logic              rd_mode,
  output logic [ADDR_W-1:0] addr
);

  localparam int HI_W = ADDR_W - BYTE_W;

  wac_sel_e          sel;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] nxt;
  logic              page_wrap;
  logic              array_wrap;

  wac_ctrl u_ctrl (
    .load_lo (load_lo),
    .step    (step),
    .rd_mode (rd_mode),
    .sel     (sel)
  );

  wac_hi_stage #(.HI_W(HI_W)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hi (load_hi),
    .load_lo (load_lo),
    .hi_in   (addr_byte[HI_W-1:0]),
    .hi_q    (hi_q)
  );

  wac_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_next (
    .cur        (addr),
    .hi_q       (hi_q),
    .lo_byte    (addr_byte),
    .sel        (sel),
    .nxt        (nxt),
    .page_wrap  (page_wrap),
    .array_wrap (array_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) addr <= '0;
    else        addr <= nxt;
  end

endmodule

// File: rtl/wac_checker.sv
module wac_checker #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_hi,
  input logic              load_lo,
  input logic [BYTE_W-1:0] addr_byte,
  input logic              step,
  input logic              rd_mode,
  input logic [ADDR_W-1:0] addr,
  input logic              page_wrap,
  input logic              array_wrap
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> addr == '0); // R1

  AST_HI_ONLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi && !load_lo && !step) |=> $stable(addr)); // R2

  AST_LOAD_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> addr[BYTE_W-1:0] == $past(addr_byte)); // R3

  AST_WRITE_STEP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rd_mode && !load_lo) |=>
      (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
      (addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1))); // R4

  AST_PAGE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    page_wrap |=> addr[PAGE_W-1:0] == '0); // R4

  AST_READ_STEP_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rd_mode && !load_lo) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R5

  AST_ARRAY_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    array_wrap |=> addr == '0); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hi && !load_lo && !step) |=> $stable(addr)); // R6

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lo && step) |=> addr[BYTE_W-1:0] == $past(addr_byte)); // R7

endmodule

bind word_addr_ctr wac_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_wac_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_hi    (load_hi),
  .load_lo    (load_lo),
  .addr_byte  (addr_byte),
  .step       (step),
  .rd_mode    (rd_mode),
  .addr       (addr),
  .page_wrap  (page_wrap),
  .array_wrap (array_wrap)
);

// File: tb/word_addr_ctr_bench.sv
`timescale 1ns/1ps
module word_addr_ctr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_hi = 1'b0;
  logic        load_lo = 1'b0;
  logic [7:0]  addr_byte = 8'h00;
  logic        step = 1'b0;
  logic        rd_mode = 1'b0;
  logic [14:0] addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  word_addr_ctr u_word_addr_ctr (
    .clk (clk), .rst_n (rst_n), .load_hi (load_hi), .load_lo (load_lo),
    .addr_byte (addr_byte), .step (step), .rd_mode (rd_mode), .addr (addr)
  );

  typedef struct {
    int    exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  // Independent reference state.
  int mdl_addr = 0;
  int mdl_hi   = 0;

  task automatic check_now(input int exp, input string tag);
    n_cmp++;
    if (int'(addr) != exp) begin
      n_bad++;
      $display("FAIL %s: addr=0x%04h expected=0x%04h", tag, addr, exp);
    end
  endtask

  // Scoreboard monitor: compares half a cycle after the edge that made the result.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check_now(it.exp, it.tag);
    end
  end

  task automatic drive(input bit hi, input bit lo, input bit st, input bit rd,
                       input logic [7:0] b, input string tag);
    sb_item_t it;
    @(negedge clk);
    load_hi = hi; load_lo = lo; step = st; rd_mode = rd; addr_byte = b;
    if (lo) mdl_addr = mdl_hi * 256 + int'(b);
    else if (st && rd) mdl_addr = (mdl_addr + 1) % 32768;
    else if (st) mdl_addr = (mdl_addr / 64) * 64 + ((mdl_addr % 64) + 1) % 64;
    if (hi && !lo) mdl_hi = int'(b) % 128;
    @(posedge clk);
    #1;
    it.exp = mdl_addr; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic load(input int a, input string tag);
    drive(1, 0, 0, 0, 8'((a / 256) | 128), tag);
    drive(0, 1, 0, 0, 8'(a % 256), tag);
  endtask

  task automatic do_reset(input string tag);
    sb_item_t it;
    @(negedge clk);
    rst_n = 1'b0; load_hi = 0; load_lo = 0; step = 0;
    mdl_addr = 0; mdl_hi = 0;
    @(posedge clk);
    #1;
    it.exp = 0; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_now(0, "R1 reset value");

    // R2: high byte only, top bit set and ignored
    drive(1, 0, 0, 0, 8'h85, "R2 load_hi leaves addr");
    drive(0, 0, 0, 0, 8'h00, "R2 still unchanged");
    drive(0, 1, 0, 0, 8'h3E, "R3 load gives 0x053E");
    // R4: in-page increment and wrap
    drive(0, 0, 1, 0, 8'h00, "R4 write step 0x053F");
    drive(0, 0, 1, 0, 8'h00, "R4 write wrap to 0x0500");
    drive(0, 0, 1, 0, 8'h00, "R4 write step 0x0501");
    // R6: hold across idle cycles
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 8'hFF, "R6 idle hold");
    // R5: read crosses page boundary
    load(16'h013F, "R3 load 0x013F");
    drive(0, 0, 1, 1, 8'h00, "R5 read step to next page 0x0140");
    load(16'h7FFF, "R3 load 0x7FFF");
    drive(0, 0, 1, 1, 8'h00, "R5 read wrap to 0x0000");
    drive(0, 0, 1, 1, 8'h00, "R5 read step 0x0001");
    load(16'h7FFF, "R3 load 0x7FFF again");
    drive(0, 0, 1, 0, 8'h00, "R4 write wrap to 0x7FC0");
    // R8: low-byte only reuses staged high bits
    drive(0, 1, 0, 0, 8'h10, "R8 reuse staged high 0x7F10");
    // R7: load beats step
    drive(1, 0, 0, 0, 8'h22, "R2 stage 0x22");
    drive(0, 1, 1, 1, 8'h44, "R7 load over step 0x2244");
    drive(0, 1, 1, 0, 8'h3F, "R7 load over write step 0x223F");
    // burst of writes around a full page
    for (int i = 0; i < 66; i++) drive(0, 0, 1, 0, 8'h00, "R4 page burst");
    // R1: reset mid-run clears address and staged high bits
    drive(1, 0, 0, 0, 8'h5A, "R2 stage before reset");
    do_reset("R1 mid-run reset");
    drive(0, 1, 0, 0, 8'h77, "R1 staged high cleared 0x0077");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule